// File: doc/BRIEF.md
# Cross-Word Likelihood Propagator with Language-Model Gating

This block runs the word-boundary step of a frame-synchronous Viterbi search. Once every in-word state of the current frame has been scored, each word whose final state survived is handed to the block. It gets the likelihood of that final state and the best bigram score leaving the word. That likelihood is then pushed into the entry states of successor words. The block keeps an on-chip array with one signed likelihood per successor word. The array is wiped to the most negative value at the start of a frame and is read out through a registered port by the next frame's in-word search.

For each ending word, the block first tests whether the best bigram score plus the final-state likelihood is above the language-model threshold. On this one test it tells the memory side either to fetch that word's successor list or to skip the list completely. When the list is fetched, it arrives as a handshaked stream of (score, successor index) pairs, and an end flag marks the last pair. Each pair is tested against the same threshold. A pair that survives enters a two-stage read-compare-write pipeline, which keeps the larger of the stored and the new likelihood. A result still in flight is forwarded, so back-to-back pairs aimed at the same successor never see a stale value.

Top module: `interword_prop`

## Requirements
- R1: After reset `fetch_en`, `fetch_skip` and `pr_ready` are low, and `wrd_ready` is low while `dp_done` is low.
- R2: A `clear_start` pulse seen while idle writes the most negative value (sign bit set, all other bits clear) into every entry. This takes exactly NUM_WORDS cycles, during which `wrd_ready` and `pr_ready` stay low.
- R3: An ending word is accepted (`wrd_ready` high) only while `dp_done` is high and the block is idle.
- R4: One cycle after a word is accepted, exactly one of `fetch_en` or `fetch_skip` pulses for one cycle. `fetch_en` pulses when `wrd_like + wrd_best > lm_thresh` (signed, strict). Otherwise `fetch_skip` pulses, including when the sum equals the threshold.
- R5: After a skip, no pairs are taken (`pr_ready` stays low), the array is unchanged and the block is idle again.
- R6: A pair whose `wrd_like + pr_score` is not above `lm_thresh` leaves the array unchanged.
- R7: A pair whose sum is above the threshold sets entry `pr_idx` to the larger of its stored value and the sum.
- R8: Consecutive pairs to the same index, taken in back-to-back cycles, give the same result as if each update had completed before the next one.
- R9: The pair that carries `pr_last` closes the list. From the next cycle `pr_ready` is low and a new word may be accepted.
- R10: `rd_like` shows the entry selected by `rd_idx` one clock edge later, and includes every update whose pair was accepted at least two edges earlier.
- R11: A surviving sum above the largest positive value is stored as that largest value, `2^(LW-1)-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dp_done | input | 1 | In-word state updates of the frame are finished |
| clear_start | input | 1 | Start wiping the successor array (frame start) |
| lm_thresh | input | LW | Signed language-model threshold |
| wrd_valid | input | 1 | Ending-word header valid |
| wrd_ready | output | 1 | Ending-word header accepted |
| wrd_like | input | LW | Signed final-state likelihood of the ending word |
| wrd_best | input | LW | Signed best bigram score leaving the word |
| fetch_en | output | 1 | One-cycle pulse: fetch this word's successor list |
| fetch_skip | output | 1 | One-cycle pulse: do not fetch the list |
| pr_valid | input | 1 | Successor pair valid |
| pr_ready | output | 1 | Successor pair accepted |
| pr_score | input | LW | Signed bigram score of the pair |
| pr_idx | input | IW | Successor word index |
| pr_last | input | 1 | This pair ends the word's list |
| rd_idx | input | IW | Readout index |
| rd_like | output | LW | Registered readout of the selected entry |

## Verification
The hazard that matters is when the stage-2 write of one pair and the stage-1 read of the next pair target the same successor entry in the same cycle. The bench provokes it with back-to-back pairs to one index, using rising, falling and equal candidates and a mix of surviving and pruned neighbours. It then reads the whole array back and compares it with a max-of-sums model computed in the bench. The threshold edge cases are the other focus: a sum equal to the threshold and a sum that saturates.

// File: rtl/iw_pkg.sv
// Shared types of the cross-word likelihood propagator.
package iw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_LIST  = 2'd2
    } iw_state_e;
endpackage

// File: rtl/iw_score_check.sv
// Adds a likelihood and a bigram score one bit wider than the operands,
// reports whether the sum is strictly above the threshold, and returns
// the sum saturated back to LW bits. Assumes two's-complement operands.
module iw_score_check #(
    parameter int LW = 24
) (
    input  logic signed [LW-1:0] base,
    input  logic signed [LW-1:0] delta,
    input  logic signed [LW-1:0] thresh,
    output logic                 above,
    output logic signed [LW-1:0] total
);
    logic signed [LW:0] wide;

    // widen, compare against the threshold, clamp on overflow
    always_comb begin
        wide  = $signed({base[LW-1], base}) + $signed({delta[LW-1], delta});
        above = wide > $signed({thresh[LW-1], thresh});
        if (wide[LW] != wide[LW-1])
            total = wide[LW] ? $signed({1'b1, {(LW-1){1'b0}}})
                             : $signed({1'b0, {(LW-1){1'b1}}});
        else
            total = wide[LW-1:0];
    end
endmodule

// File: rtl/iw_like_ram.sv
// Successor entry-likelihood array: one write port, one combinational
// read port for the update pipeline, one registered read port for readout.
// Assumes addresses are below DEPTH.
module iw_like_ram #(
    parameter int DEPTH = 5000,
    parameter int LW    = 24,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [LW-1:0] wdata,
    input  logic [AW-1:0] qa_addr,
    output logic [LW-1:0] qa_data,
    input  logic [AW-1:0] qb_addr,
    output logic [LW-1:0] qb_data
);
    logic [LW-1:0] cells [DEPTH];

    // single write port
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // registered readout port
    always_ff @(posedge clk) begin
        qb_data <= cells[qb_addr];
    end

    assign qa_data = cells[qa_addr];
endmodule

// File: rtl/iw_update_pipe.sv
// Two-stage max-update. Stage 1 reads the stored likelihood (forwarding
// the stage-2 result on an index match) and registers it with the
// candidate. Stage 2 writes the candidate when it is larger.
// Assumes in_valid is only raised for candidates that passed the threshold.
module iw_update_pipe #(
    parameter int LW = 24,
    parameter int AW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [AW-1:0]        in_idx,
    input  logic signed [LW-1:0] in_cand,
    output logic [AW-1:0]        rd_addr,
    input  logic signed [LW-1:0] rd_data,
    output logic                 wr_en,
    output logic [AW-1:0]        wr_idx,
    output logic signed [LW-1:0] wr_data,
    output logic                 busy
);
    logic                 s1_v;
    logic [AW-1:0]        s1_idx;
    logic signed [LW-1:0] s1_cand;
    logic signed [LW-1:0] s1_old;
    logic                 s2_win;
    logic signed [LW-1:0] prior;

    assign rd_addr = in_idx;
    assign s2_win  = s1_cand > s1_old;

    // stage-1 operand: forward the pending stage-2 write when indices match
    always_comb begin
        if (s1_v && s2_win && (s1_idx == in_idx))
            prior = s1_cand;
        else
            prior = rd_data;
    end

    // stage-1 valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) s1_v <= 1'b0;
        else        s1_v <= in_valid;
    end

    // stage-1 data registers
    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_idx  <= in_idx;
            s1_cand <= in_cand;
            s1_old  <= prior;
        end
    end

    assign wr_en   = s1_v && s2_win;
    assign wr_idx  = s1_idx;
    assign wr_data = s1_cand;
    assign busy    = s1_v;
endmodule

// File: rtl/interword_prop.sv
// Top of the cross-word likelihood propagator. Sequences array clearing,
// the per-word gate on the best bigram score, and the successor pair
// stream into the update pipeline.
// Assumes lm_thresh is held steady while a word is being processed.
module interword_prop #(
    parameter int NUM_WORDS = 5000,
    parameter int LW        = 24,
    localparam int IW       = $clog2(NUM_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dp_done,
    input  logic          clear_start,
    input  logic [LW-1:0] lm_thresh,
    input  logic          wrd_valid,
    output logic          wrd_ready,
    input  logic [LW-1:0] wrd_like,
    input  logic [LW-1:0] wrd_best,
    output logic          fetch_en,
    output logic          fetch_skip,
    input  logic          pr_valid,
    output logic          pr_ready,
    input  logic [LW-1:0] pr_score,
    input  logic [IW-1:0] pr_idx,
    input  logic          pr_last,
    input  logic [IW-1:0] rd_idx,
    output logic [LW-1:0] rd_like
);
    import iw_pkg::*;

    localparam logic [LW-1:0] MOST_NEG  = {1'b1, {(LW-1){1'b0}}};
    localparam logic [IW-1:0] LAST_CELL = IW'(NUM_WORDS - 1);

    iw_state_e     st;
    logic [IW-1:0] clr_cnt;
    logic [LW-1:0] like_r;
    logic          clearing;
    logic          upd_busy;
    logic          word_pass, pair_pass;
    logic [LW-1:0] word_sum, pair_sum;
    logic          word_acc, pair_acc, clr_go;
    logic [IW-1:0] ra_addr, upd_idx;
    logic [LW-1:0] ra_data, upd_data;
    logic          upd_we;
    logic          ram_we;
    logic [IW-1:0] ram_waddr;
    logic [LW-1:0] ram_wdata;

    assign clearing  = (st == ST_CLEAR);
    assign wrd_ready = (st == ST_IDLE) && dp_done && !clear_start;
    assign pr_ready  = (st == ST_LIST);
    assign word_acc  = wrd_valid && wrd_ready;
    assign pair_acc  = pr_valid && pr_ready;
    assign clr_go    = clear_start && (st == ST_IDLE) && !upd_busy;

    // first-level gate: ending likelihood plus best bigram score
    iw_score_check #(.LW(LW)) u_word_chk (
        .base(wrd_like), .delta(wrd_best), .thresh(lm_thresh),
        .above(word_pass), .total(word_sum)
    );

    // second-level gate: held likelihood plus each pair score
    iw_score_check #(.LW(LW)) u_pair_chk (
        .base(like_r), .delta(pr_score), .thresh(lm_thresh),
        .above(pair_pass), .total(pair_sum)
    );

    // control sequence: idle, clearing, or consuming a successor list
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            clr_cnt    <= '0;
            like_r     <= '0;
            fetch_en   <= 1'b0;
            fetch_skip <= 1'b0;
        end else begin
            fetch_en   <= 1'b0;
            fetch_skip <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (clr_go) begin
                        st      <= ST_CLEAR;
                        clr_cnt <= '0;
                    end else if (word_acc) begin
                        like_r <= wrd_like;
                        if (word_pass) begin
                            fetch_en <= 1'b1;
                            st       <= ST_LIST;
                        end else begin
                            fetch_skip <= 1'b1;
                        end
                    end
                end
                ST_CLEAR: begin
                    clr_cnt <= clr_cnt + 1'b1;
                    if (clr_cnt == LAST_CELL) st <= ST_IDLE;
                end
                ST_LIST: begin
                    if (pair_acc && pr_last) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    iw_update_pipe #(.LW(LW), .AW(IW)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pair_acc && pair_pass), .in_idx(pr_idx), .in_cand(pair_sum),
        .rd_addr(ra_addr), .rd_data(ra_data),
        .wr_en(upd_we), .wr_idx(upd_idx), .wr_data(upd_data),
        .busy(upd_busy)
    );

    // write-port source: clear sweep or pipeline update (never together)
    always_comb begin
        ram_we    = clearing || upd_we;
        ram_waddr = clearing ? clr_cnt  : upd_idx;
        ram_wdata = clearing ? MOST_NEG : upd_data;
    end

    iw_like_ram #(.DEPTH(NUM_WORDS), .LW(LW), .AW(IW)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .qa_addr(ra_addr), .qa_data(ra_data),
        .qb_addr(rd_idx), .qb_data(rd_like)
    );

    // unused byproduct of the first-level gate
    logic unused_sum;
    assign unused_sum = ^word_sum;
endmodule

// File: rtl/iw_checker.sv
// Protocol and sequencing properties of interword_prop, bound to the top.
module iw_checker (
    input logic clk,
    input logic rst_n,
    input logic dp_done,
    input logic wrd_valid,
    input logic wrd_ready,
    input logic fetch_en,
    input logic fetch_skip,
    input logic pr_valid,
    input logic pr_ready,
    input logic pr_last,
    input logic clearing,
    input logic upd_busy
);
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_en && fetch_skip));

    a_r4_decides: assert property (@(posedge clk) disable iff (!rst_n)
        (wrd_valid && wrd_ready) |=> (fetch_en || fetch_skip));

    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en || fetch_skip) |-> $past(wrd_valid && wrd_ready));

    a_r3_wait_dp: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_done |-> !wrd_ready);

    a_r5_skip_no_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_skip |-> !pr_ready);

    a_r9_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_valid && pr_ready && pr_last) |=> !pr_ready);

    a_r2_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> (!wrd_ready && !pr_ready));

    a_r6_pipe_source: assert property (@(posedge clk) disable iff (!rst_n)
        upd_busy |-> $past(pr_valid && pr_ready));
endmodule

bind interword_prop iw_checker u_iw_checker (
    .clk(clk), .rst_n(rst_n), .dp_done(dp_done),
    .wrd_valid(wrd_valid), .wrd_ready(wrd_ready),
    .fetch_en(fetch_en), .fetch_skip(fetch_skip),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_last(pr_last),
    .clearing(clearing), .upd_busy(upd_busy)
);

// File: tb/test_interword_prop.sv
module test_interword_prop;
    localparam int NW   = 16;
    localparam int LW   = 10;
    localparam int IW   = 4;
    localparam int VMIN = -512;
    localparam int VMAX = 511;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dp_done = 1'b0, clear_start = 1'b0;
    logic [LW-1:0] lm_thresh = '0, wrd_like = '0, wrd_best = '0, pr_score = '0;
    logic wrd_valid = 1'b0, pr_valid = 1'b0, pr_last = 1'b0;
    logic [IW-1:0] pr_idx = '0, rd_idx = '0;
    logic wrd_ready, fetch_en, fetch_skip, pr_ready;
    logic [LW-1:0] rd_like;

    int checks = 0, failures = 0, cyc = 0;
    int model [NW];
    int pidx [16];
    int psc [16];

    always #4 clk = ~clk;

    interword_prop #(.NUM_WORDS(NW), .LW(LW)) i_interword_prop (
        .clk(clk), .rst_n(rst_n), .dp_done(dp_done), .clear_start(clear_start),
        .lm_thresh(lm_thresh), .wrd_valid(wrd_valid), .wrd_ready(wrd_ready),
        .wrd_like(wrd_like), .wrd_best(wrd_best), .fetch_en(fetch_en),
        .fetch_skip(fetch_skip), .pr_valid(pr_valid), .pr_ready(pr_ready),
        .pr_score(pr_score), .pr_idx(pr_idx), .pr_last(pr_last),
        .rd_idx(rd_idx), .rd_like(rd_like)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // read every entry through the registered port and compare with the model
    task automatic check_array(string req);
        for (int i = 0; i < NW; i++) begin
            rd_idx = IW'(i);
            @(negedge clk);
            check(req, int'($signed(rd_like)), model[i]);
        end
    endtask

    task automatic do_clear();
        int n = 0;
        clear_start = 1'b1;
        @(negedge clk);
        clear_start = 1'b0;
        while (!wrd_ready && n < 100) begin
            if (pr_ready) check("R2 pr_ready during clear", 1, 0);
            n++;
            @(negedge clk);
        end
        check("R2 clear duration", n, NW);
        for (int i = 0; i < NW; i++) model[i] = VMIN;
        check_array("R2 cleared entry");
    endtask

    // one ending word with n pairs from pidx/psc; verifies decision and array
    task automatic do_word(int like, int best, int thr, int n, string req);
        bit pass;
        pass = (like + best) > thr;
        lm_thresh = LW'(thr);
        wrd_like = LW'(like);
        wrd_best = LW'(best);
        wrd_valid = 1'b1;
        while (!wrd_ready) @(negedge clk);
        @(negedge clk);
        wrd_valid = 1'b0;
        check("R4 fetch_en", int'(fetch_en), int'(pass));
        check("R4 fetch_skip", int'(fetch_skip), int'(!pass));
        if (!pass) begin
            for (int c = 0; c < 3; c++) begin
                check("R5 no pairs after skip", int'(pr_ready), 0);
                @(negedge clk);
            end
            check("R5 idle after skip", int'(wrd_ready), 1);
        end else begin
            for (int k = 0; k < n; k++) begin
                int s;
                pr_valid = 1'b1;
                pr_idx = IW'(pidx[k]);
                pr_score = LW'(psc[k]);
                pr_last = (k == n - 1);
                while (!pr_ready) @(negedge clk);
                @(negedge clk);
                s = like + psc[k];
                if (s > VMAX) s = VMAX;
                if ((like + psc[k]) > thr && s > model[pidx[k]]) model[pidx[k]] = s;
            end
            pr_valid = 1'b0;
            pr_last = 1'b0;
            check("R9 list closed", int'(pr_ready), 0);
            check("R9 next word allowed", int'(wrd_ready), 1);
            @(negedge clk);
        end
        check_array(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wrd_ready", int'(wrd_ready), 0);
        check("R1 pr_ready", int'(pr_ready), 0);
        check("R1 fetch_en", int'(fetch_en), 0);
        check("R1 fetch_skip", int'(fetch_skip), 0);

        dp_done = 1'b1;
        do_clear();

        // R3: no acceptance while in-word updates are still running
        dp_done = 1'b0;
        wrd_valid = 1'b1;
        wrd_like = LW'(100);
        wrd_best = LW'(0);
        lm_thresh = LW'(0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R3 wrd_ready held low", int'(wrd_ready), 0);
            check("R3 no decision", int'(fetch_en | fetch_skip), 0);
        end
        wrd_valid = 1'b0;
        dp_done = 1'b1;
        @(negedge clk);

        // R4 boundary: sum equal to threshold is skipped
        do_word(20, 30, 50, 0, "R5 array after skip");

        // R6 boundary: pair sum equal to threshold ignored, one above taken
        pidx[0] = 2; psc[0] = 0;
        pidx[1] = 4; psc[1] = 5;
        do_word(0, 5, 0, 2, "R6 R7 threshold pairs");

        // R8: back-to-back same-index pairs, rising, falling, equal, pruned
        pidx[0] = 7; psc[0] = 10;
        pidx[1] = 7; psc[1] = 50;
        pidx[2] = 7; psc[2] = 20;
        pidx[3] = 9; psc[3] = 30;
        pidx[4] = 9; psc[4] = 60;
        pidx[5] = 9; psc[5] = 60;
        pidx[6] = 9; psc[6] = -400;
        pidx[7] = 9; psc[7] = 70;
        do_word(0, 70, -300, 8, "R8 forwarded max");

        // R11: saturation at the largest positive value
        pidx[0] = 3; psc[0] = 100;
        pidx[1] = 3; psc[1] = 11;
        do_word(500, 100, 0, 2, "R11 saturated entry");

        // R7/R10 sweep over many words, thresholds and index patterns
        for (int w = 0; w < 24; w++) begin
            int like, thr, best;
            like = ((w * 71) % 300) - 200;
            thr = ((w * 29) % 200) - 150;
            best = -1000;
            for (int k = 0; k < 8; k++) begin
                pidx[k] = (k % 4 == 1) ? pidx[k-1] : ((w * 3 + k * 7) % NW);
                psc[k] = ((w * 37 + k * 53) % 200) - 150;
                if (psc[k] > best) best = psc[k];
            end
            do_word(like, best, thr, 8, "R7 R10 sweep entry");
        end

        do_clear();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule